// File: doc/BRIEF.md
# Extension Slot Pipeline Arbiter

This block sits between the fetch stage of an in-order pipeline and a small set of pluggable execution units, called slots. Every slot looks at the fetched instruction on its own and raises a request when it recognises an opcode it implements. The arbiter picks one requester by fixed priority, or none. With no winner the base decoder takes the instruction. Every requesting slot sees either a grant or a deny.

The winning slot then owns the pipeline until it signals that it has finished. Only the winner reaches the shared register-file read and write ports. The winner's next-PC value goes to fetch; this value already skips the whole basic block the unit replaces. The winner's stall request goes to hazard control. Its exception flag and faulting virtual PC go to the exception logic. Its register numbers go to the forwarding and hazard logic. On the done cycle, one of two re-entry strobes picks whether the unit's results join the datapath at the memory-access stage or at the writeback stage. A flush from an older instruction cancels any grant without side effects.

Top module: `ext_pipe_arbiter`

## Requirements
- R1: When `fetch_valid` is high, no slot owns the pipeline and `flush` is low, the requesting slot with the lowest index is granted. At no time is more than one bit of `slot_grant` set.
- R2: Every slot whose `slot_req` bit is high sees exactly one of its `slot_grant` or `slot_deny` bits set. No deny is given to a slot that does not request.
- R3: With no grant and a valid fetch, `base_sel` is 1 and `next_pc` equals `fetch_pc + 4`. `base_sel` is 0 whenever a grant is active or `flush` is high.
- R4: While a slot is granted, `next_pc` carries that slot's field of `slot_next_pc`. Slot k occupies bits [k*XLEN +: XLEN], and the same layout applies to every per-slot vector.
- R5: A grant is held, with `fetch_hold` high and every other requester denied, until the winner raises its `slot_done` bit. In the done cycle `fetch_hold` is 0, and the next cycle arbitrates anew. A done raised in the cycle the grant is issued means no hold at all.
- R6: When `flush` is high, `slot_grant` and `fetch_hold` are 0 and every requester is denied. A grant held from an earlier cycle is dropped and does not return when `flush` falls.
- R7: `rf_rs_addr`, `rf_rt_addr`, `rf_wr_addr`, `rf_wr_data` and `rf_wr_en` come only from the granted slot. `rf_wr_en` is 0 when no slot is granted.
- R8: In the winner's done cycle, `reenter_wb` is 1 if that slot's `slot_stage_wb` bit is 1, and `reenter_ma` is 1 if that bit is 0. Outside a done cycle both are 0.
- R9: `pipe_stall` follows the granted slot's `slot_stall` bit only. Stall bits from other slots have no effect.
- R10: `exc_valid` and `exc_vpc` follow the granted slot's `slot_exc` bit and `slot_exc_vpc` field. Exceptions from other slots are ignored, and `exc_vpc` is 0 without a grant.
- R11: `haz_valid` is 1 only while a grant is active. `haz_rs`, `haz_rt` and `haz_rd` then carry the winner's register numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A fetched instruction is present |
| fetch_pc | input | XLEN | PC of the fetched instruction |
| flush | input | 1 | Branch flush or exception from an older instruction |
| slot_req | input | NSLOT | Per-slot claim of the fetched instruction |
| slot_done | input | NSLOT | Per-slot finish and re-enter strobe |
| slot_stall | input | NSLOT | Per-slot request for more cycles |
| slot_stage_wb | input | NSLOT | Per-slot re-entry stage: 1 writeback, 0 memory access |
| slot_next_pc | input | NSLOT*XLEN | Per-slot PC after the replaced block |
| slot_exc | input | NSLOT | Per-slot exception flag |
| slot_exc_vpc | input | NSLOT*XLEN | Per-slot virtual PC of the faulting replaced instruction |
| slot_rs | input | NSLOT*REGW | Per-slot first source register |
| slot_rt | input | NSLOT*REGW | Per-slot second source register |
| slot_rd | input | NSLOT*REGW | Per-slot destination register |
| slot_wr_en | input | NSLOT | Per-slot register write enable |
| slot_wr_data | input | NSLOT*XLEN | Per-slot register write data |
| slot_grant | output | NSLOT | One-hot grant |
| slot_deny | output | NSLOT | Deny for requesters that did not win |
| base_sel | output | 1 | Base decoder executes the fetched instruction |
| next_pc | output | XLEN | PC that fetch uses next |
| fetch_hold | output | 1 | Suppress the next fetch while a slot is busy |
| pipe_stall | output | 1 | Stall toward hazard control |
| reenter_ma | output | 1 | Winner's results enter at memory access |
| reenter_wb | output | 1 | Winner's results enter at writeback |
| exc_valid | output | 1 | Exception reported by the winner |
| exc_vpc | output | XLEN | Virtual PC reported with the exception |
| rf_rs_addr | output | REGW | Register-file read address A |
| rf_rt_addr | output | REGW | Register-file read address B |
| rf_wr_addr | output | REGW | Register-file write address |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_data | output | XLEN | Register-file write data |
| haz_valid | output | 1 | Hazard register numbers are valid |
| haz_rs | output | REGW | Winner's first source register |
| haz_rt | output | REGW | Winner's second source register |
| haz_rd | output | REGW | Winner's destination register |

## Verification
The bench builds the arbiter with NSLOT=3, XLEN=32 and REGW=5. Three slots are enough to give a winner, a lower-priority requester that must be denied, and an idle slot whose stall, exception and write-enable bits must be ignored. Each slot gets distinct next-PC, exception-PC, register-number and write-data values, so a routing fault that picks the wrong slot changes a checked output. Both re-entry stage settings are used. A flush is tried once in a fresh arbitration cycle and once against a held grant.

// File: rtl/ext_arb_pkg.sv
`timescale 1ns/1ps
package ext_arb_pkg;
  localparam int MAX_SLOTS = 16;
  localparam int PC_STEP   = 4;

  typedef enum logic {
    STAGE_MA = 1'b0,
    STAGE_WB = 1'b1
  } reentry_e;

  // isolate the lowest set bit of a request vector
  function automatic logic [MAX_SLOTS-1:0] lowest_set(input logic [MAX_SLOTS-1:0] v);
    return v & (~v + MAX_SLOTS'(1));
  endfunction
endpackage

// File: rtl/ext_prio_pick.sv
`timescale 1ns/1ps
module ext_prio_pick #(
  parameter int N = 4
) (
  input  logic         enable,
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  import ext_arb_pkg::*;
  logic [MAX_SLOTS-1:0] req_wide;
  logic [MAX_SLOTS-1:0] pick_wide;

  always_comb begin
    req_wide        = '0;
    req_wide[N-1:0] = enable ? req : '0;
    pick_wide       = lowest_set(req_wide);
    pick            = pick_wide[N-1:0];
  end
endmodule

// File: rtl/ext_grant_ctrl.sv
`timescale 1ns/1ps
module ext_grant_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fetch_valid,
  input  logic         flush,
  input  logic [N-1:0] req,
  input  logic [N-1:0] done,
  output logic [N-1:0] cur_mask,
  output logic         busy,
  output logic         done_hit
);
  logic [N-1:0] owner_q;
  logic [N-1:0] pick_oh;
  logic         arb_en;

  assign busy   = |owner_q;
  assign arb_en = fetch_valid & ~busy & ~flush;

  ext_prio_pick #(.N(N)) u_pick (
    .enable (arb_en),
    .req    (req),
    .pick   (pick_oh)
  );

  assign cur_mask = flush ? '0 : (busy ? owner_q : pick_oh);
  assign done_hit = |(cur_mask & done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner_q <= '0;
    else if (flush)    owner_q <= '0;
    else if (done_hit) owner_q <= '0;
    else if (!busy)    owner_q <= pick_oh;
  end
endmodule

// File: rtl/ext_route_mux.sv
`timescale 1ns/1ps
module ext_route_mux #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] data,
  output logic [W-1:0]   out
);
  always_comb begin
    out = '0;
    for (int i = 0; i < N; i++)
      out = out | (data[i*W +: W] & {W{sel[i]}});
  end
endmodule

// File: rtl/ext_pipe_arbiter.sv
`timescale 1ns/1ps
module ext_pipe_arbiter #(
  parameter int NSLOT = 4,
  parameter int XLEN  = 32,
  parameter int REGW  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_valid,
  input  logic [XLEN-1:0]       fetch_pc,
  input  logic                  flush,
  input  logic [NSLOT-1:0]      slot_req,
  input  logic [NSLOT-1:0]      slot_done,
  input  logic [NSLOT-1:0]      slot_stall,
  input  logic [NSLOT-1:0]      slot_stage_wb,
  input  logic [NSLOT*XLEN-1:0] slot_next_pc,
  input  logic [NSLOT-1:0]      slot_exc,
  input  logic [NSLOT*XLEN-1:0] slot_exc_vpc,
  input  logic [NSLOT*REGW-1:0] slot_rs,
  input  logic [NSLOT*REGW-1:0] slot_rt,
  input  logic [NSLOT*REGW-1:0] slot_rd,
  input  logic [NSLOT-1:0]      slot_wr_en,
  input  logic [NSLOT*XLEN-1:0] slot_wr_data,
  output logic [NSLOT-1:0]      slot_grant,
  output logic [NSLOT-1:0]      slot_deny,
  output logic                  base_sel,
  output logic [XLEN-1:0]       next_pc,
  output logic                  fetch_hold,
  output logic                  pipe_stall,
  output logic                  reenter_ma,
  output logic                  reenter_wb,
  output logic                  exc_valid,
  output logic [XLEN-1:0]       exc_vpc,
  output logic [REGW-1:0]       rf_rs_addr,
  output logic [REGW-1:0]       rf_rt_addr,
  output logic [REGW-1:0]       rf_wr_addr,
  output logic                  rf_wr_en,
  output logic [XLEN-1:0]       rf_wr_data,
  output logic                  haz_valid,
  output logic [REGW-1:0]       haz_rs,
  output logic [REGW-1:0]       haz_rt,
  output logic [REGW-1:0]       haz_rd
);
  import ext_arb_pkg::*;

  function automatic logic [XLEN-1:0] seq_pc(input logic [XLEN-1:0] pc);
    return pc + XLEN'(PC_STEP);
  endfunction

  // named internal events
  logic [NSLOT-1:0] win_mask;
  logic             owner_busy;
  logic             win_done;
  logic             any_grant;
  reentry_e         win_stage;
  logic [XLEN-1:0]  win_npc;
  logic [REGW-1:0]  win_rs, win_rt, win_rd;

  ext_grant_ctrl #(.N(NSLOT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .flush       (flush),
    .req         (slot_req),
    .done        (slot_done),
    .cur_mask    (win_mask),
    .busy        (owner_busy),
    .done_hit    (win_done)
  );

  ext_route_mux #(.N(NSLOT), .W(XLEN)) u_mux_npc (.sel(win_mask), .data(slot_next_pc), .out(win_npc));
  ext_route_mux #(.N(NSLOT), .W(XLEN)) u_mux_exc (.sel(win_mask), .data(slot_exc_vpc), .out(exc_vpc));
  ext_route_mux #(.N(NSLOT), .W(XLEN)) u_mux_wd  (.sel(win_mask), .data(slot_wr_data), .out(rf_wr_data));
  ext_route_mux #(.N(NSLOT), .W(REGW)) u_mux_rs  (.sel(win_mask), .data(slot_rs),      .out(win_rs));
  ext_route_mux #(.N(NSLOT), .W(REGW)) u_mux_rt  (.sel(win_mask), .data(slot_rt),      .out(win_rt));
  ext_route_mux #(.N(NSLOT), .W(REGW)) u_mux_rd  (.sel(win_mask), .data(slot_rd),      .out(win_rd));

  assign any_grant  = |win_mask;
  assign win_stage  = reentry_e'(|(win_mask & slot_stage_wb));

  assign slot_grant = win_mask;
  assign slot_deny  = slot_req & ~win_mask;
  assign base_sel   = fetch_valid & ~flush & ~owner_busy & ~any_grant;
  assign next_pc    = any_grant ? win_npc : seq_pc(fetch_pc);
  assign fetch_hold = any_grant & ~win_done;
  assign pipe_stall = |(win_mask & slot_stall);
  assign reenter_ma = win_done & (win_stage == STAGE_MA);
  assign reenter_wb = win_done & (win_stage == STAGE_WB);
  assign exc_valid  = |(win_mask & slot_exc);

  assign rf_rs_addr = win_rs;
  assign rf_rt_addr = win_rt;
  assign rf_wr_addr = win_rd;
  assign rf_wr_en   = |(win_mask & slot_wr_en);

  assign haz_valid  = any_grant;
  assign haz_rs     = win_rs;
  assign haz_rt     = win_rt;
  assign haz_rd     = win_rd;
endmodule

// File: rtl/ext_pipe_arbiter_chk.sv
`timescale 1ns/1ps
module ext_pipe_arbiter_chk #(
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             flush,
  input logic [NSLOT-1:0] slot_req,
  input logic [NSLOT-1:0] slot_done,
  input logic [NSLOT-1:0] slot_grant,
  input logic [NSLOT-1:0] slot_deny,
  input logic             base_sel,
  input logic             fetch_hold,
  input logic             rf_wr_en,
  input logic             reenter_ma,
  input logic             reenter_wb
);
  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_grant));

  p_grant_deny_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_grant & slot_deny) == '0) && ((slot_deny & ~slot_req) == '0));

  p_base_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    base_sel |-> (slot_grant == '0) && fetch_valid && !flush);

  p_hold_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hold && !flush) |=> (flush || (slot_grant == $past(slot_grant))));

  p_flush_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (slot_grant == '0) && !fetch_hold);

  p_rf_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (slot_grant != '0));

  p_reenter_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reenter_ma || reenter_wb) |-> !(reenter_ma && reenter_wb) && ((slot_grant & slot_done) != '0));
endmodule

bind ext_pipe_arbiter ext_pipe_arbiter_chk #(.NSLOT(NSLOT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .flush       (flush),
  .slot_req    (slot_req),
  .slot_done   (slot_done),
  .slot_grant  (slot_grant),
  .slot_deny   (slot_deny),
  .base_sel    (base_sel),
  .fetch_hold  (fetch_hold),
  .rf_wr_en    (rf_wr_en),
  .reenter_ma  (reenter_ma),
  .reenter_wb  (reenter_wb)
);

// File: tb/ext_pipe_arbiter_test.sv
`timescale 1ns/1ps
module ext_pipe_arbiter_test;
  localparam int NS = 3;
  localparam int XL = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic fetch_valid, flush;
  logic [XL-1:0] fetch_pc;
  logic [NS-1:0] slot_req, slot_done, slot_stall, slot_stage_wb, slot_exc, slot_wr_en;
  logic [NS*XL-1:0] slot_next_pc, slot_exc_vpc, slot_wr_data;
  logic [NS*RW-1:0] slot_rs, slot_rt, slot_rd;
  logic [NS-1:0] slot_grant, slot_deny;
  logic base_sel, fetch_hold, pipe_stall, reenter_ma, reenter_wb, exc_valid, rf_wr_en, haz_valid;
  logic [XL-1:0] next_pc, exc_vpc, rf_wr_data;
  logic [RW-1:0] rf_rs_addr, rf_rt_addr, rf_wr_addr, haz_rs, haz_rt, haz_rd;

  ext_pipe_arbiter #(.NSLOT(NS), .XLEN(XL), .REGW(RW)) uut (.*);

  int checks = 0;
  int errors = 0;

  function automatic logic [XL-1:0] npc_of(int k);   return 32'h1000_0000 + 32'(k) * 32'h100; endfunction
  function automatic logic [XL-1:0] epc_of(int k);   return 32'h2000_0010 + 32'(k) * 4; endfunction
  function automatic logic [XL-1:0] wd_of(int k);    return 32'hA5A5_0000 + 32'(k); endfunction
  function automatic logic [RW-1:0] rs_of(int k);    return RW'(k + 1); endfunction
  function automatic logic [RW-1:0] rt_of(int k);    return RW'(k + 9); endfunction
  function automatic logic [RW-1:0] rd_of(int k);    return RW'(k + 17); endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // advance one clock, then drive just after the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    fetch_valid = 1'b0; flush = 1'b0; fetch_pc = '0;
    slot_req = '0; slot_done = '0; slot_stall = '0; slot_exc = '0;
  endtask

  task automatic t_reset();
    idle_inputs();
    #1;
    check("R6 reset grant", 64'(slot_grant), 64'd0);
    check("R5 reset hold", 64'(fetch_hold), 64'd0);
    check("R11 reset haz_valid", 64'(haz_valid), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    step();
  endtask

  task automatic t_base_path();
    fetch_valid = 1'b1; fetch_pc = 32'h0000_0400; slot_req = '0;
    #1;
    check("R3 base_sel", 64'(base_sel), 64'd1);
    check("R3 next_pc seq", 64'(next_pc), 64'h404);
    check("R7 no write without grant", 64'(rf_wr_en), 64'd0);
    check("R10 no exc without grant", 64'(exc_valid), 64'd0);
    check("R10 exc_vpc zero", 64'(exc_vpc), 64'd0);
    check("R9 no stall without grant", 64'(pipe_stall), 64'd0);
    step();
  endtask

  task automatic t_priority_single();
    fetch_valid = 1'b1; fetch_pc = 32'h0000_0800;
    slot_req = 3'b110; slot_done = 3'b010;
    #1;
    check("R1 lowest wins", 64'(slot_grant), 64'b010);
    check("R2 loser denied", 64'(slot_deny), 64'b100);
    check("R3 base off", 64'(base_sel), 64'd0);
    check("R4 winner npc", 64'(next_pc), 64'(npc_of(1)));
    check("R5 no hold on immediate done", 64'(fetch_hold), 64'd0);
    check("R8 wb reentry", 64'(reenter_wb), 64'd1);
    check("R8 ma quiet", 64'(reenter_ma), 64'd0);
    step();
    slot_req = 3'b000; slot_done = '0;
    #1;
    check("R5 released", 64'(slot_grant), 64'd0);
    check("R3 base after release", 64'(base_sel), 64'd1);
    step();
  endtask

  task automatic t_hold_and_route();
    fetch_valid = 1'b1; fetch_pc = 32'h0000_0C00;
    slot_req = 3'b001;
    #1;
    check("R1 slot0 granted", 64'(slot_grant), 64'b001);
    check("R5 hold raised", 64'(fetch_hold), 64'd1);
    check("R8 no reentry before done", 64'(reenter_ma | reenter_wb), 64'd0);
    step();
    slot_req = 3'b010; slot_stall = 3'b110; slot_exc = 3'b100;
    #1;
    check("R5 grant held", 64'(slot_grant), 64'b001);
    check("R2 newcomer denied", 64'(slot_deny), 64'b010);
    check("R9 foreign stall ignored", 64'(pipe_stall), 64'd0);
    check("R10 foreign exc ignored", 64'(exc_valid), 64'd0);
    check("R7 rs routed", 64'(rf_rs_addr), 64'(rs_of(0)));
    check("R7 rt routed", 64'(rf_rt_addr), 64'(rt_of(0)));
    check("R7 wa routed", 64'(rf_wr_addr), 64'(rd_of(0)));
    check("R7 wd routed", 64'(rf_wr_data), 64'(wd_of(0)));
    check("R7 we from winner", 64'(rf_wr_en), 64'd0);
    check("R11 haz valid", 64'(haz_valid), 64'd1);
    check("R11 haz rd", 64'(haz_rd), 64'(rd_of(0)));
    check("R11 haz rs", 64'(haz_rs), 64'(rs_of(0)));
    step();
    slot_stall = 3'b001; slot_exc = 3'b001;
    #1;
    check("R9 winner stall", 64'(pipe_stall), 64'd1);
    check("R10 winner exc", 64'(exc_valid), 64'd1);
    check("R10 winner vpc", 64'(exc_vpc), 64'(epc_of(0)));
    step();
    slot_stall = '0; slot_exc = '0; slot_done = 3'b001;
    #1;
    check("R5 hold drops on done", 64'(fetch_hold), 64'd0);
    check("R8 ma reentry", 64'(reenter_ma), 64'd1);
    check("R4 npc at done", 64'(next_pc), 64'(npc_of(0)));
    step();
    slot_done = '0;
    #1;
    check("R5 fresh arbitration", 64'(slot_grant), 64'b010);
    check("R7 we slot1", 64'(rf_wr_en), 64'd1);
    check("R7 wd slot1", 64'(rf_wr_data), 64'(wd_of(1)));
    slot_done = 3'b010;
    step();
    slot_req = '0; slot_done = '0;
    step();
  endtask

  task automatic t_flush();
    fetch_valid = 1'b1; fetch_pc = 32'h0000_1000;
    slot_req = 3'b100; flush = 1'b1;
    #1;
    check("R6 flush no grant", 64'(slot_grant), 64'd0);
    check("R6 flush deny", 64'(slot_deny), 64'b100);
    check("R6 flush no hold", 64'(fetch_hold), 64'd0);
    check("R3 flush no base", 64'(base_sel), 64'd0);
    step();
    flush = 1'b0; slot_req = '0;
    #1;
    check("R6 nothing latched", 64'(slot_grant), 64'd0);
    step();
    slot_req = 3'b100;
    #1;
    check("R1 slot2 alone", 64'(slot_grant), 64'b100);
    step();
    slot_req = '0; flush = 1'b1;
    #1;
    check("R6 held grant cancelled", 64'(slot_grant), 64'd0);
    step();
    flush = 1'b0;
    #1;
    check("R6 ownership dropped", 64'(slot_grant), 64'd0);
    check("R6 hold gone", 64'(fetch_hold), 64'd0);
    check("R3 base resumes", 64'(base_sel), 64'd1);
    check("R3 seq pc", 64'(next_pc), 64'h1004);
    step();
  endtask

  initial begin
    for (int k = 0; k < NS; k++) begin
      slot_next_pc[k*XL +: XL] = npc_of(k);
      slot_exc_vpc[k*XL +: XL] = epc_of(k);
      slot_wr_data[k*XL +: XL] = wd_of(k);
      slot_rs[k*RW +: RW] = rs_of(k);
      slot_rt[k*RW +: RW] = rt_of(k);
      slot_rd[k*RW +: RW] = rd_of(k);
    end
    slot_stage_wb = 3'b010;
    slot_wr_en    = 3'b110;
    t_reset();
    t_base_path();
    t_priority_single();
    t_hold_and_route();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000ns;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule